// File: doc/BRIEF.md
# MDIO Managed-Device Register Responder

This block plays the managed-device role on a two-wire management link. It watches the management clock and the shared data line and picks frames out of the bit stream. It holds a local bank of 32 registers of 16 bits each. Write frames aimed at it update one register. Read frames aimed at it are answered by driving the line for the second turnaround bit and the register contents, after which the line is released again.

Both link wires are oversampled in the block's own system clock domain. A rising edge of the management clock is found after a small synchroniser. Incoming bits are taken at that edge. Outgoing bits are updated a few system cycles after the edge, so they are stable well before the next rising edge.

The device answers its configured address, which must be nonzero. It also accepts writes sent to address 0, so that one broadcast command reaches every device. Reads to address 0 go unanswered, because several devices answering at once would collide on the line. The register bank is exposed on a flat output so that its contents can be observed.

The block has no streaming data path. All of its pins are plain control and data pins with no valid/ready handshake, and the link itself sets the pace.

Top module: `mdio_responder`

## Requirements
- R1: After reset every register reads 0 and the output enable for the data line is low.
- R2: A frame is accepted only after at least 32 consecutive one bits, followed by a 0 then a 1. A frame that follows only 31 ones leaves the bank unchanged. A preamble longer than 32 ones is accepted.
- R3: The frame order is: start, 2-bit opcode, 5-bit device address, 5-bit register address, 2 turnaround bits, 16 data bits. Every field is sent MSB first. A write uses opcode 01, and its 16 data bits are stored into the addressed register.
- R4: A write sent to device address 0 is stored in the same way as a write to the device's own address.
- R5: A frame sent to any address other than the device's own address or 0 changes no register. The device never drives the line while a frame is being received.
- R6: A read uses opcode 10. For a read to its own address, the device leaves the first turnaround bit undriven and drives the second turnaround bit as 0. It then drives register bits 15 down to 0, one per clock.
- R7: After the last data bit of a read, the device releases the line: the output enable is low by the next bit.
- R8: A read sent to address 0 is never answered: the output enable stays low for the whole frame.
- R9: Frames with opcode 00 or 11 are ignored. The bank is unchanged and the line is not driven.
- R10: A write whose turnaround bits are not 1 then 0 is dropped, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock from the link |
| mdio_i | input | 1 | Current level of the shared data line |
| phy_addr_i | input | 5 | Configured device address (nonzero) |
| mdio_o | output | 1 | Value driven onto the data line while enabled |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| reg_bank_o | output | 512 | All registers, register n at bits n*16 and up |

## Verification
The bench builds the block with its default parameters: 32 registers of 16 bits, a 32-bit preamble threshold and a two-stage synchroniser. It runs the management clock at one sixteenth of the system clock. With these settings the exact preamble threshold is tested at both 31 and 40 ones. Every register address can be hit by random writes, reads and broadcast writes. The bench checks the bit timing of the turnaround and the release by sampling the line just before each management clock edge.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
  typedef enum logic [2:0] {
    S_HUNT, S_START, S_OP, S_PHY, S_REG, S_TA1, S_TA2, S_DATA
  } fsm_t;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdio_s
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '1;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], mdc_i};
      dat_pipe <= {dat_pipe[STAGES-2:0], mdio_i};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign mdc_rise = clk_pipe[STAGES-1] & ~clk_last;
  assign mdio_s   = dat_pipe[STAGES-1];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_rise |=> !mdc_rise); // R2
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] bank_flat
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_addr == ADDR_W'(i)) regs[i] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign bank_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_flat)); // R3
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_resp_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              drv_oe_o,
  output logic              drv_val_o
);
  localparam int CNT_W  = $clog2(DATA_W + ADDR_W);
  localparam int ONES_W = $clog2(PRE_LEN + 1);
  localparam logic [ONES_W-1:0] ONES_FULL = ONES_W'(PRE_LEN);
  localparam logic [CNT_W-1:0]  LAST_ADR  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0]  LAST_DAT  = CNT_W'(DATA_W - 1);

  fsm_t              state;
  logic [ONES_W-1:0] ones;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] phy;
  logic [ADDR_W-1:0] rega;
  logic [DATA_W-1:0] sh;
  logic              rd_ans;

  logic [ADDR_W-1:0] rega_n;
  logic              hit_any, hit_own;
  assign rega_n  = {rega[ADDR_W-2:0], bit_val};
  assign hit_own = (phy == own_addr) && (own_addr != '0);
  assign hit_any = hit_own || (phy == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_HUNT;
      ones      <= '0;
      cnt       <= '0;
      op        <= '0;
      phy       <= '0;
      rega      <= '0;
      sh        <= '0;
      rd_ans    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      drv_oe_o  <= 1'b0;
      drv_val_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (bit_rise) begin
        if (!bit_val)               ones <= '0;
        else if (ones != ONES_FULL) ones <= ones + 1'b1;
        unique case (state)
          S_HUNT: if (!bit_val && ones == ONES_FULL) state <= S_START;
          S_START: begin
            cnt   <= '0;
            state <= bit_val ? S_OP : S_HUNT;
          end
          S_OP: begin
            op <= {op[0], bit_val};
            if (cnt == '0) cnt <= 1;
            else begin
              cnt   <= '0;
              state <= ({op[0], bit_val} == OP_WR || {op[0], bit_val} == OP_RD)
                       ? S_PHY : S_HUNT;
            end
          end
          S_PHY: begin
            phy <= {phy[ADDR_W-2:0], bit_val};
            if (cnt == LAST_ADR) begin
              cnt   <= '0;
              state <= S_REG;
            end else cnt <= cnt + 1'b1;
          end
          S_REG: begin
            rega <= rega_n;
            if (cnt == LAST_ADR) begin
              cnt <= '0;
              if (op == OP_RD && hit_own) begin
                rd_ans <= 1'b1;
                state  <= S_TA1;
              end else if (op == OP_WR && hit_any) begin
                rd_ans <= 1'b0;
                state  <= S_TA1;
              end else state <= S_HUNT;
            end else cnt <= cnt + 1'b1;
          end
          S_TA1: begin
            if (rd_ans) begin
              drv_oe_o  <= 1'b1;
              drv_val_o <= 1'b0;
              sh        <= rd_data;
              state     <= S_TA2;
            end else state <= bit_val ? S_TA2 : S_HUNT;
          end
          S_TA2: begin
            cnt <= '0;
            if (rd_ans) begin
              drv_val_o <= sh[DATA_W-1];
              sh        <= {sh[DATA_W-2:0], 1'b0};
              state     <= S_DATA;
            end else state <= bit_val ? S_HUNT : S_DATA;
          end
          S_DATA: begin
            if (rd_ans) begin
              if (cnt == LAST_DAT) begin
                drv_oe_o  <= 1'b0;
                drv_val_o <= 1'b0;
                rd_ans    <= 1'b0;
                state     <= S_HUNT;
              end else begin
                drv_val_o <= sh[DATA_W-1];
                sh        <= {sh[DATA_W-2:0], 1'b0};
                cnt       <= cnt + 1'b1;
              end
            end else begin
              sh <= {sh[DATA_W-2:0], bit_val};
              if (cnt == LAST_DAT) begin
                wr_en_o   <= 1'b1;
                wr_data_o <= {sh[DATA_W-2:0], bit_val};
                state     <= S_HUNT;
              end else cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  assign reg_addr_o = rega;

  AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe_o |-> (rd_ans && (state == S_TA2 || state == S_DATA))); // R7
  AST_NO_BCAST_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe_o |-> (phy != '0)); // R8
  AST_TA_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe_o && state == S_TA2) |-> !drv_val_o); // R6
  AST_OE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe_o) |-> $past(bit_rise)); // R6
  AST_WR_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (phy == own_addr || phy == '0)); // R5
  AST_WR_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (op == OP_WR)); // R9
endmodule

// File: rtl/mdio_responder.sv
module mdio_responder #(
  parameter int NUM_REGS    = 32,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mdc_i,
  input  logic                       mdio_i,
  input  logic [ADDR_W-1:0]          phy_addr_i,
  output logic                       mdio_o,
  output logic                       mdio_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] reg_bank_o
);
  logic              rise, bit_s, wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .mdc_rise(rise), .mdio_s(bit_s)
  );

  mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_rise(rise), .bit_val(bit_s),
    .own_addr(phy_addr_i), .rd_data(rd_data), .reg_addr_o(reg_addr),
    .wr_en_o(wr_en), .wr_data_o(wr_data),
    .drv_oe_o(mdio_oe_o), .drv_val_o(mdio_o)
  );

  mdio_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_addr),
    .wr_data(wr_data), .rd_addr(reg_addr), .rd_data(rd_data),
    .bank_flat(reg_bank_o)
  );
endmodule

// File: tb/tb_mdio_responder.sv
module tb_mdio_responder;
  localparam int H  = 8;
  localparam int NR = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, mdc, tb_oe, tb_val;
  logic [4:0]    own;
  logic          dut_o, dut_oe;
  logic [511:0]  bank;
  wire           line = dut_oe ? dut_o : (tb_oe ? tb_val : 1'b1);

  int total = 0, bad = 0, clash = 0;
  logic [15:0] model [NR];

  mdio_responder dut (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(line), .phy_addr_i(own),
    .mdio_o(dut_o), .mdio_oe_o(dut_oe), .reg_bank_o(bank)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic slot(input logic drv, input logic v, output logic s, output logic o);
    tb_oe = drv; tb_val = v;
    repeat (H) @(negedge clk);
    s = line; o = dut_oe;
    if (drv && dut_oe) clash++;
    mdc = 1'b1;
    repeat (H) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic bits(input logic [15:0] v, input int w);
    logic s, o;
    for (int i = w - 1; i >= 0; i--) slot(1'b1, v[i], s, o);
  endtask

  task automatic head(input int pre, input logic [1:0] op, input logic [4:0] phy,
                      input logic [4:0] ra);
    logic s, o;
    slot(1'b1, 1'b0, s, o);
    for (int i = 0; i < pre; i++) slot(1'b1, 1'b1, s, o);
    bits(16'b01, 2); bits({14'b0, op}, 2); bits({11'b0, phy}, 5); bits({11'b0, ra}, 5);
  endtask

  task automatic wframe(input int pre, input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] d);
    logic s, o;
    head(pre, op, phy, ra);
    bits({14'b0, ta}, 2); bits(d, 16);
    slot(1'b0, 1'b1, s, o);
  endtask

  task automatic rframe(input logic [4:0] phy, input logic [4:0] ra,
                        output logic [15:0] d, output logic ta1_oe, output logic ta2_oe,
                        output logic ta2_v, output int drv, output logic end_oe);
    logic s, o;
    head(32, 2'b10, phy, ra);
    slot(1'b0, 1'b1, s, o); ta1_oe = o;
    slot(1'b0, 1'b1, s, o); ta2_oe = o; ta2_v = s;
    drv = (ta1_oe ? 1 : 0) + (ta2_oe ? 1 : 0);
    for (int i = 15; i >= 0; i--) begin
      slot(1'b0, 1'b1, s, o); d[i] = s; if (o) drv++;
    end
    slot(1'b0, 1'b1, s, o); end_oe = o;
  endtask

  function automatic logic [15:0] slice(input logic [511:0] b, input int r);
    return b[r*16 +: 16];
  endfunction

  logic done = 1'b0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic a, b, c, e; int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0; mdc = 1'b0; tb_oe = 1'b0; tb_val = 1'b1; own = 5'd9;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "bank after reset", {31'b0, bank == '0}, 32'd1);
    chk("R1", "oe after reset", {31'b0, dut_oe}, 32'd0);

    wframe(32, 2'b01, 5'd9, 5'd5, 2'b10, 16'hA5C3); model[5] = 16'hA5C3;
    chk("R3", "write own reg5", slice(bank, 5), 16'hA5C3);

    rframe(5'd9, 5'd5, d, a, b, c, n, e);
    chk("R6", "ta1 undriven", {31'b0, a}, 0);
    chk("R6", "ta2 driven", {31'b0, b}, 1);
    chk("R6", "ta2 value", {31'b0, c}, 0);
    chk("R6", "read data", d, 16'hA5C3);
    chk("R6", "driven bits", n, 17);
    chk("R7", "released after data", {31'b0, e}, 0);

    wframe(32, 2'b01, 5'd0, 5'd7, 2'b10, 16'h1234); model[7] = 16'h1234;
    chk("R4", "broadcast write", slice(bank, 7), 16'h1234);

    rframe(5'd0, 5'd7, d, a, b, c, n, e);
    chk("R8", "broadcast read drive count", n, 0);

    wframe(32, 2'b01, 5'd12, 5'd5, 2'b10, 16'hFFFF);
    chk("R5", "other address write", slice(bank, 5), 16'hA5C3);
    rframe(5'd12, 5'd5, d, a, b, c, n, e);
    chk("R5", "other address read drive count", n, 0);

    wframe(32, 2'b00, 5'd9, 5'd5, 2'b10, 16'h0F0F);
    chk("R9", "opcode 00", slice(bank, 5), 16'hA5C3);
    wframe(32, 2'b11, 5'd9, 5'd5, 2'b10, 16'h0F0F);
    chk("R9", "opcode 11", slice(bank, 5), 16'hA5C3);
    chk("R9", "no drive during bad opcodes", {31'b0, dut_oe}, 0);

    wframe(32, 2'b01, 5'd9, 5'd5, 2'b11, 16'h5555);
    chk("R10", "turnaround 11", slice(bank, 5), 16'hA5C3);
    wframe(32, 2'b01, 5'd9, 5'd5, 2'b00, 16'h5555);
    chk("R10", "turnaround 00", slice(bank, 5), 16'hA5C3);

    wframe(31, 2'b01, 5'd9, 5'd5, 2'b10, 16'h6666);
    chk("R2", "31-one preamble", slice(bank, 5), 16'hA5C3);
    wframe(40, 2'b01, 5'd9, 5'd5, 2'b10, 16'h6666); model[5] = 16'h6666;
    chk("R2", "40-one preamble", slice(bank, 5), 16'h6666);

    for (int it = 0; it < 28; it++) begin
      logic [4:0] ra, pa; logic [15:0] dv; int k;
      ra = 5'($urandom_range(0, 31)); dv = 16'($urandom);
      k  = $urandom_range(0, 3);
      pa = (k == 0) ? 5'd0 : (k == 1) ? 5'd17 : 5'd9;
      wframe(32, 2'b01, pa, ra, 2'b10, dv);
      if (pa != 5'd17) model[ra] = dv;
      chk("R3", "random write", slice(bank, ra), model[ra]);
      rframe(5'd9, ra, d, a, b, c, n, e);
      chk("R6", "random read", d, model[ra]);
    end

    n = 0;
    for (int i = 0; i < NR; i++) if (slice(bank, i) !== model[i]) n++;
    chk("R3", "full bank mismatches", n, 0);
    chk("R5", "bus contention slots", clash, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule